// File: doc/BRIEF.md
# JTAG TMS/TDI Launch Timing Unit

This block drives the TMS and TDI pins toward a JTAG target, timed from the return clock that comes back from the target. A shifter running at TCK rate offers one TMS/TDI pair per TCK period. The unit takes that pair on the selected return-clock edge, which is rising by default or falling when the alternate mode is chosen. The falling edge moves every launch half a TCK period later. Each pair then passes through a link-delay pipeline of 3 to 5 TCK periods. That delay absorbs the round trip through the isolation barrier: for each full return-clock period by which the launch latency exceeds one period, the setting is raised by one.

When a launch edge arrives, the pair that is due is held. Each pin then waits its own fine offset, counted in base-clock steps by a down-counter, and the pin register loads when that count reaches zero. TMS and TDI are kept from switching on the same base-clock cycle. Configuration fields outside their legal ranges are clamped.

The return-clock edges reach the unit as one-cycle strobes that are already synchronised to the base clock. The input side is a valid/ready stream. Ready rises only in the cycle of a launch-edge strobe, and it does not depend on valid. The shifter holds its pair until a transfer happens. If valid is low on a launch edge, the pipeline takes in a copy of the last accepted pair, so the pins keep their levels while the shifter stalls.

Top module: `jtag_launch_timer`

## Requirements
- R1: While reset is asserted, and after it until the first launch, `tms_o` and `tdi_o` are 1. `in_ready` is 0 in every cycle that has no launch-edge strobe.
- R2: With `fall_mode`=0, `ret_rise` is the launch edge. `in_ready` equals 1 in exactly the cycles where `ret_rise` is 1, and a pair transfers when `in_valid` and `in_ready` are both 1.
- R3: With `fall_mode`=1, `ret_fall` is the launch edge and `ret_rise` has no effect on `in_ready` or on the pins.
- R4: A pair accepted on launch edge k is the value launched in response to launch edge k+L, where L is the effective link delay. Before L launch edges have passed, the launched value is 1 on both pins.
- R5: The `link_dly` field is clamped: values 0 to 2 act as 3, values 3 to 5 act as themselves, and values 6 and 7 act as 5.
- R6: If a launch strobe is high in cycle t, `tms_o` shows its new value from cycle t+2+Ot, where Ot is the effective TMS offset. It holds its previous value through cycle t+1+Ot.
- R7: `tdi_o` follows the same timing with its own effective offset Od. When the clamped TDI offset equals the clamped TMS offset, Od is that value plus one.
- R8: The offset fields are clamped: values 8 to 15 act as 7.
- R9: On a launch edge where `in_valid` is 0, the pipeline takes in a repeat of the last accepted pair, or 1/1 if no pair has been accepted yet.
- R10: `tms_o` and `tdi_o` never both change in the same base-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock for all timing steps |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_rise | input | 1 | One-cycle strobe marking a synchronised rising return-clock edge |
| ret_fall | input | 1 | One-cycle strobe marking a synchronised falling return-clock edge |
| fall_mode | input | 1 | 1 selects the falling edge as the launch edge |
| tms_ofs | input | 4 | TMS fine offset in base-clock steps, clamped to 7 |
| tdi_ofs | input | 4 | TDI fine offset in base-clock steps, clamped to 7 |
| link_dly | input | 3 | Link delay in TCK periods, clamped to the range 3 to 5 |
| in_valid | input | 1 | Shifter offers a TMS/TDI pair |
| in_tms | input | 1 | Offered TMS bit |
| in_tdi | input | 1 | Offered TDI bit |
| in_ready | output | 1 | Unit takes the offered pair in this cycle |
| tms_o | output | 1 | Timed TMS pin |
| tdi_o | output | 1 | Timed TDI pin |

## Verification
The assertions assume that `ret_rise` and `ret_fall` are never high in the same cycle. They also assume that the configuration is stable while out of reset, and that successive launch edges are further apart than the largest effective offset plus two cycles. Under those conditions one pin's pending load cannot overlap the next launch. The stimulus meets all three: it emits a rising strobe and a falling strobe 12 cycles apart in a 24-cycle TCK period, and it changes configuration only while reset is held. The sweep covers both edge modes, every raw link-delay code, and offset pairs chosen to hit clamping and equal offsets.

// File: rtl/jlt_pkg.sv
package jlt_pkg;
  localparam int LNK_MIN  = 3;
  localparam int LNK_MAX  = 5;
  localparam int LNK_W    = $clog2(LNK_MAX + 1);
  localparam int OFS_MAX  = 7;
  localparam int OFS_IN_W = 4;
  localparam int CNT_W    = $clog2(OFS_MAX + 2);

  typedef struct packed {
    logic tms;
    logic tdi;
  } jpair_t;

  function automatic logic [LNK_W-1:0] clamp_lnk(input logic [LNK_W-1:0] v);
    if (v < LNK_W'(LNK_MIN))      return LNK_W'(LNK_MIN);
    else if (v > LNK_W'(LNK_MAX)) return LNK_W'(LNK_MAX);
    else                          return v;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_ofs(input logic [OFS_IN_W-1:0] v);
    if (v > OFS_IN_W'(OFS_MAX)) return CNT_W'(OFS_MAX);
    else                        return CNT_W'(v);
  endfunction
endpackage

// File: rtl/jlt_link_pipe.sv
module jlt_link_pipe #(
  parameter int DEPTH = 5,
  parameter int W     = 2,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             take,
  input  logic [W-1:0]     d,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     q
);
  logic [W-1:0] st [DEPTH];

  // stage 0 keeps the last accepted pair when nothing new transfers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           st[0] <= '1;
    else if (adv && take) st[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st[i] <= '1;
      else if (adv) st[i] <= st[i-1];
    end
  end

  always_comb begin
    q = st[0];
    for (int i = 0; i < DEPTH; i++)
      if (sel == SEL_W'(i + 1)) q = st[i];
  end

  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st[DEPTH-1])); // R4
endmodule

// File: rtl/jlt_ofs_launch.sv
module jlt_ofs_launch #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [CW-1:0] ofs,
  input  logic          d,
  output logic          q
);
  logic          armed;
  logic          pend;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b1;
      cnt   <= '0;
      q     <= 1'b1;
    end else if (fire) begin
      armed <= 1'b1;
      pend  <= d;
      cnt   <= ofs;
    end else if (armed) begin
      if (cnt == '0) begin
        q     <= pend;
        armed <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> ($past(armed) && $past(cnt) == '0)); // R6
endmodule

// File: rtl/jtag_launch_timer.sv
module jtag_launch_timer
  import jlt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ret_rise,
  input  logic                ret_fall,
  input  logic                fall_mode,
  input  logic [OFS_IN_W-1:0] tms_ofs,
  input  logic [OFS_IN_W-1:0] tdi_ofs,
  input  logic [LNK_W-1:0]    link_dly,
  input  logic                in_valid,
  input  logic                in_tms,
  input  logic                in_tdi,
  output logic                in_ready,
  output logic                tms_o,
  output logic                tdi_o
);
  localparam int NSIG = 2;

  logic             launch;
  logic [LNK_W-1:0] lnk_eff;
  logic [CNT_W-1:0] tms_oe, tdi_cl, tdi_oe;
  jpair_t           in_pair, due_pair;
  logic [CNT_W-1:0] ofs_v [NSIG];
  logic             d_v   [NSIG];
  logic             q_v   [NSIG];

  assign launch   = fall_mode ? ret_fall : ret_rise;
  assign in_ready = launch;
  assign in_pair  = '{tms: in_tms, tdi: in_tdi};

  always_comb begin
    lnk_eff = clamp_lnk(link_dly);
    tms_oe  = clamp_ofs(tms_ofs);
    tdi_cl  = clamp_ofs(tdi_ofs);
    tdi_oe  = (tdi_cl == tms_oe) ? tdi_cl + 1'b1 : tdi_cl;
  end

  jlt_link_pipe #(.DEPTH(LNK_MAX), .W($bits(jpair_t)), .SEL_W(LNK_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (launch),
    .take  (in_valid),
    .d     (in_pair),
    .sel   (lnk_eff),
    .q     (due_pair)
  );

  assign ofs_v[0] = tms_oe;
  assign ofs_v[1] = tdi_oe;
  assign d_v[0]   = due_pair.tms;
  assign d_v[1]   = due_pair.tdi;

  for (genvar g = 0; g < NSIG; g++) begin : g_pin
    jlt_ofs_launch #(.CW(CNT_W)) u_launch (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (launch),
      .ofs   (ofs_v[g]),
      .d     (d_v[g]),
      .q     (q_v[g])
    );
  end

  assign tms_o = q_v[0];
  assign tdi_o = q_v[1];

  AST_NO_SAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(tms_o) && !$stable(tdi_o))); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_rise && ret_fall)); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_rise && !ret_fall) |-> !in_ready); // R1
endmodule

// File: tb/tb_jtag_launch_timer.sv
`timescale 1ns/1ps
module tb_jtag_launch_timer;
  import jlt_pkg::*;

  localparam int NPER = 12;
  localparam int PER  = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ret_rise, ret_fall, fall_mode, in_valid, in_tms, in_tdi;
  logic in_ready, tms_o, tdi_o;
  logic [OFS_IN_W-1:0] tms_ofs, tdi_ofs;
  logic [LNK_W-1:0]    link_dly;

  int n_chk = 0;
  int n_fail = 0;
  bit acc_tms [NPER];
  bit acc_tdi [NPER];

  jtag_launch_timer dut (
    .clk(clk), .rst_n(rst_n), .ret_rise(ret_rise), .ret_fall(ret_fall),
    .fall_mode(fall_mode), .tms_ofs(tms_ofs), .tdi_ofs(tdi_ofs),
    .link_dly(link_dly), .in_valid(in_valid), .in_tms(in_tms),
    .in_tdi(in_tdi), .in_ready(in_ready), .tms_o(tms_o), .tdi_o(tdi_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit tms_f(int k, int s); return ((k * 5 + s) % 7) < 3;  endfunction
  function automatic bit tdi_f(int k, int s); return ((k * 3 + s) % 5) >= 2; endfunction
  function automatic bit vld_f(int k);        return (k % 4) != 2;           endfunction
  function automatic bit mtms(int j); return (j < 0) ? 1'b1 : acc_tms[j]; endfunction
  function automatic bit mtdi(int j); return (j < 0) ? 1'b1 : acc_tdi[j]; endfunction

  task automatic run_cfg(input bit fm, input int lk, input int to, input int dof, input int s);
    int le, toe, doe, lp;
    bit pt, pd;
    string tg;
    rst_n = 1'b0; ret_rise = 0; ret_fall = 0; in_valid = 0; in_tms = 0; in_tdi = 0;
    fall_mode = fm; link_dly = LNK_W'(lk);
    tms_ofs = OFS_IN_W'(to); tdi_ofs = OFS_IN_W'(dof);
    repeat (3) @(negedge clk);
    #1;
    chk(tms_o == 1'b1 && tdi_o == 1'b1, "R1 reset pins", {tms_o, tdi_o}, 3);
    chk(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
    rst_n = 1'b1;
    le  = (lk < 3) ? 3 : (lk > 5) ? 5 : lk;
    toe = (to > 7) ? 7 : to;
    doe = (dof > 7) ? 7 : dof;
    if (doe == toe) doe++;
    lp = fm ? 12 : 0;
    for (int k = 0; k < NPER; k++) begin
      if (vld_f(k)) begin
        acc_tms[k] = tms_f(k, s); acc_tdi[k] = tdi_f(k, s);
      end else begin
        acc_tms[k] = (k == 0) ? 1'b1 : acc_tms[k-1];
        acc_tdi[k] = (k == 0) ? 1'b1 : acc_tdi[k-1];
      end
    end
    tg = $sformatf("%s R4%s%s%s", fm ? "R3" : "R2", (lk != le) ? " R5" : "",
                   (to > 7 || dof > 7) ? " R8" : "",
                   (((dof > 7) ? 7 : dof) == toe) ? " R7" : "");
    pt = 1'b1; pd = 1'b1;
    for (int p = 0; p < NPER * PER; p++) begin
      int ph, k;
      string t2;
      ph = p % PER; k = p / PER;
      @(negedge clk);
      ret_rise = (ph == 0);
      ret_fall = (ph == 12);
      in_valid = vld_f(k);
      in_tms   = tms_f(k, s);
      in_tdi   = tdi_f(k, s);
      #1;
      if (tms_o !== pt || tdi_o !== pd)
        chk(!(tms_o !== pt && tdi_o !== pd), "R10 both pins moved", 1, 0);
      pt = tms_o; pd = tdi_o;
      if (ph == lp) chk(in_ready == 1'b1, {tg, " ready on launch edge"}, in_ready, 1);
      if (ph == (lp + 12) % PER)
        chk(in_ready == 1'b0, "R3 R2 other edge ignored", in_ready, 0);
      t2 = (k - le >= 0 && !vld_f(k - le)) ? {tg, " R9"} : tg;
      if (ph == lp + 1 + toe)
        chk(tms_o == mtms(k - 1 - le), {t2, " R6 tms before"}, tms_o, mtms(k - 1 - le));
      if (ph == lp + 2 + toe)
        chk(tms_o == mtms(k - le), {t2, " R6 tms after"}, tms_o, mtms(k - le));
      if (ph == lp + 1 + doe)
        chk(tdi_o == mtdi(k - 1 - le), {t2, " R7 tdi before"}, tdi_o, mtdi(k - 1 - le));
      if (ph == lp + 2 + doe)
        chk(tdi_o == mtdi(k - le), {t2, " R7 tdi after"}, tdi_o, mtdi(k - le));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int tv [4];
    int dv [3];
    int s;
    tv = '{0, 3, 7, 12};
    dv = '{0, 3, 9};
    s = 0;
    for (int fm = 0; fm < 2; fm++)
      for (int lk = 0; lk < 8; lk++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++) begin
            run_cfg(fm[0], lk, tv[a], dv[b], s);
            s++;
          end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule